// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits in the write path of an EEPROM emulation front end. Every write strobe, with its address and data byte, passes through it before the page-write engine sees it. The block recognises short key sequences of address/data pairs. It keeps a protected or unprotected mode and decides, for each write, whether the byte may be stored in the array or must be swallowed as a command byte.

In protected mode an ordinary write is dropped. A three-write unlock key must come first. When the third key write arrives, the block opens a write window and re-arms protection at the same time. The window stays open until the page engine reports that it has started its internal write cycle. A six-write key leaves protection off, and none of its bytes ever reach the array. Each strobe yields a registered verdict one cycle later. The verdict says whether the byte is stored and whether it was consumed as a command. The current mode and the window state are also available as levels.

Top module: `wp_seq`

## Requirements
- R1: After reset, `prot_on` equals the `PROT_AT_RESET` parameter (default 1), `wr_permit` is 0 and `dec_vld` is 0.
- R2: In protected mode with the window closed, a write that matches no key step yields `dec_vld`=1, `dec_store`=0 and `dec_cmd`=0 on the cycle after the strobe.
- R3: The unlock key is data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each of these writes reports `dec_cmd`=1 and `dec_store`=0. After the third write, `wr_permit`=1 and `prot_on`=1.
- R4: While `wr_permit` is 1, every write is stored (`dec_store`=1, `dec_cmd`=0). This holds even when its address and data equal a key step.
- R5: A `page_commit` pulse closes the window: `wr_permit` reads 0 on the next cycle. If an unlock key completes in the same cycle as a `page_commit` pulse, the window opens anyway.
- R6: The disable key is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six writes report `dec_cmd`=1 and `dec_store`=0. After the sixth write, `prot_on`=0 and `wr_permit` stays 0.
- R7: In unprotected mode, a write that matches no key step is stored.
- R8: In unprotected mode, the unlock key sets `prot_on` back to 1 and opens the window.
- R9: A write that breaks a partial key resets the sequence and then follows the mode rules. If that write is 0xAA@0x5555, it is taken as the first step of a new key and hidden.
- R10: All 15 address bits are compared. An address that differs from 0x5555 or 0x2AAA in any single bit matches no key step.
- R11: A cycle without `wr_strobe` gives `dec_vld`=0 and leaves the key progress unchanged, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_strobe | input | 1 | One write per cycle while high |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data byte |
| page_commit | input | 1 | Pulse: page engine entered its internal write cycle |
| dec_vld | output | 1 | Verdict valid, one cycle after a strobe |
| dec_store | output | 1 | The byte may be written to the array |
| dec_cmd | output | 1 | The byte was consumed as a key step |
| prot_on | output | 1 | 1 = protected mode |
| wr_permit | output | 1 | Write window open after an unlock key |

## Verification
The bench targets several corner cases:

- A key broken in the middle, where the breaking write is itself 0xAA@0x5555. A design that dropped it, instead of restarting from it, would reject the following legal key.
- Addresses one bit away from the key addresses. A design with a truncated comparator would accept these and open the window.
- A pause with no strobe inside the disable key, while key-like values sit on the inputs. This catches a sequencer that advances without a strobe.
- An unlock that lands on the same cycle as a `page_commit` pulse. A clear-over-set priority would lose the window.
- A key-valued byte written inside the open window. A design that kept matching during the window would hide that byte.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Key-step patterns recognised by the matcher
  localparam int NPAT     = 5;
  localparam int PAT_AA_A = 0;
  localparam int PAT_55_B = 1;
  localparam int PAT_A0_A = 2;
  localparam int PAT_80_A = 3;
  localparam int PAT_20_A = 4;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_K1   = 3'd1,
    SQ_K2   = 3'd2,
    SQ_C3   = 3'd3,
    SQ_C4   = 3'd4,
    SQ_C5   = 3'd5
  } sq_state_e;

  function automatic logic [7:0] pat_data(input int idx);
    case (idx)
      PAT_AA_A: pat_data = 8'hAA;
      PAT_55_B: pat_data = 8'h55;
      PAT_A0_A: pat_data = 8'hA0;
      PAT_80_A: pat_data = 8'h80;
      default:  pat_data = 8'h20;
    endcase
  endfunction

  // 1 when the pattern uses the second key address
  function automatic logic pat_on_b(input int idx);
    pat_on_b = (idx == PAT_55_B);
  endfunction

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/wp_key_match.sv
module wp_key_match #(
  parameter int                ADDR_W = 15,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A  = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B  = 15'h2AAA
) (
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [wp_pkg::NPAT-1:0] hit
);

  for (genvar g = 0; g < wp_pkg::NPAT; g++) begin : g_pat
    localparam logic [ADDR_W-1:0] PA = wp_pkg::pat_on_b(g) ? KEY_B : KEY_A;
    localparam logic [DATA_W-1:0] PD = DATA_W'(wp_pkg::pat_data(g));
    assign hit[g] = (wr_addr == PA) && (wr_data == PD);
  end

endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm (
  input  logic                    clk,
  input  logic                    rst_sn,
  input  logic                    stb,
  input  logic                    bypass,
  input  logic [wp_pkg::NPAT-1:0] hit,
  output logic                    evt_cmd,
  output logic                    evt_prefix,
  output logic                    evt_disable
);
  import wp_pkg::*;

  sq_state_e state_q, state_d;
  logic      restart;

  assign restart = hit[PAT_AA_A];

  always_comb begin
    state_d     = state_q;
    evt_cmd     = 1'b0;
    evt_prefix  = 1'b0;
    evt_disable = 1'b0;
    if (stb && bypass) begin
      state_d = SQ_IDLE;
    end else if (stb) begin
      // default on mismatch: restart from this write if it is a first step
      state_d = restart ? SQ_K1 : SQ_IDLE;
      evt_cmd = restart;
      case (state_q)
        SQ_IDLE: ;
        SQ_K1: if (hit[PAT_55_B]) begin
          state_d = SQ_K2; evt_cmd = 1'b1;
        end
        SQ_K2: if (hit[PAT_A0_A]) begin
          state_d = SQ_IDLE; evt_cmd = 1'b1; evt_prefix = 1'b1;
        end else if (hit[PAT_80_A]) begin
          state_d = SQ_C3; evt_cmd = 1'b1;
        end
        SQ_C3: if (hit[PAT_AA_A]) begin
          state_d = SQ_C4; evt_cmd = 1'b1;
        end
        SQ_C4: if (hit[PAT_55_B]) begin
          state_d = SQ_C5; evt_cmd = 1'b1;
        end
        SQ_C5: if (hit[PAT_20_A]) begin
          state_d = SQ_IDLE; evt_cmd = 1'b1; evt_disable = 1'b1;
        end
        default: begin
          state_d = SQ_IDLE; evt_cmd = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)  state_q <= SQ_IDLE;
    else if (stb) state_q <= state_d;
  end

endmodule

// File: rtl/wp_mode_gate.sv
module wp_mode_gate #(
  parameter bit PROT_AT_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic stb,
  input  logic page_commit,
  input  logic evt_cmd,
  input  logic evt_prefix,
  input  logic evt_disable,
  output logic prot_on,
  output logic wr_permit,
  output logic dec_vld,
  output logic dec_store,
  output logic dec_cmd
);

  logic prot_d, permit_d, vld_d, store_d, cmd_d;

  always_comb begin
    prot_d   = prot_on;
    permit_d = wr_permit;
    if (evt_prefix)       prot_d = 1'b1;
    else if (evt_disable) prot_d = 1'b0;
    // opening the window wins over a coincident commit
    if (evt_prefix)       permit_d = 1'b1;
    else if (page_commit) permit_d = 1'b0;
    vld_d   = stb;
    cmd_d   = stb && evt_cmd;
    store_d = stb && !evt_cmd && (wr_permit || !prot_on);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      prot_on   <= PROT_AT_RESET;
      wr_permit <= 1'b0;
      dec_vld   <= 1'b0;
      dec_store <= 1'b0;
      dec_cmd   <= 1'b0;
    end else begin
      prot_on   <= prot_d;
      wr_permit <= permit_d;
      dec_vld   <= vld_d;
      dec_store <= store_d;
      dec_cmd   <= cmd_d;
    end
  end

endmodule

// File: rtl/wp_seq.sv
module wp_seq #(
  parameter int                ADDR_W        = 15,
  parameter int                DATA_W        = 8,
  parameter logic [ADDR_W-1:0] KEY_A         = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B         = 15'h2AAA,
  parameter bit                PROT_AT_RESET = 1'b1,
  parameter int                RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              page_commit,
  output logic              dec_vld,
  output logic              dec_store,
  output logic              dec_cmd,
  output logic              prot_on,
  output logic              wr_permit
);

  logic                    rst_sn;
  logic [wp_pkg::NPAT-1:0] hit;
  logic                    evt_cmd, evt_prefix, evt_disable;

  wp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  wp_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_match (
    .wr_addr(wr_addr), .wr_data(wr_data), .hit(hit)
  );

  wp_seq_fsm u_fsm (
    .clk(clk), .rst_sn(rst_sn), .stb(wr_strobe), .bypass(wr_permit), .hit(hit),
    .evt_cmd(evt_cmd), .evt_prefix(evt_prefix), .evt_disable(evt_disable)
  );

  wp_mode_gate #(.PROT_AT_RESET(PROT_AT_RESET)) u_gate (
    .clk(clk), .rst_sn(rst_sn), .stb(wr_strobe), .page_commit(page_commit),
    .evt_cmd(evt_cmd), .evt_prefix(evt_prefix), .evt_disable(evt_disable),
    .prot_on(prot_on), .wr_permit(wr_permit),
    .dec_vld(dec_vld), .dec_store(dec_store), .dec_cmd(dec_cmd)
  );

endmodule

// File: rtl/wp_seq_chk.sv
module wp_seq_chk #(
  parameter int                ADDR_W = 15,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A  = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B  = 15'h2AAA
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              wr_strobe,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              page_commit,
  input logic              dec_vld,
  input logic              dec_store,
  input logic              dec_cmd,
  input logic              prot_on,
  input logic              wr_permit
);

  logic off_key;
  assign off_key = (wr_addr != KEY_A) && (wr_addr != KEY_B);

  a_r11_no_strobe_no_verdict: assert property (@(posedge clk) disable iff (!rst_sn)
    !wr_strobe |=> !dec_vld);

  a_r2_locked_drop: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_strobe && off_key && prot_on && !wr_permit |=> dec_vld && !dec_store && !dec_cmd);

  a_r4_window_stores: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_strobe && wr_permit |=> dec_vld && dec_store && !dec_cmd);

  a_r5_commit_closes: assert property (@(posedge clk) disable iff (!rst_sn)
    page_commit && wr_permit |=> !wr_permit);

  a_r7_open_stores: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_strobe && off_key && !prot_on |=> dec_store);

  a_r3_window_implies_prot: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_permit |-> prot_on);

  a_r6_store_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_sn)
    !(dec_store && dec_cmd));

  a_r6_leave_prot_by_cmd: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(prot_on) |-> dec_cmd);

endmodule

bind wp_seq wp_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
  .page_commit(page_commit), .dec_vld(dec_vld), .dec_store(dec_store), .dec_cmd(dec_cmd),
  .prot_on(prot_on), .wr_permit(wr_permit)
);

// File: tb/wp_seq_test.sv
`timescale 1ns/1ps
module wp_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        page_commit = 1'b0;
  logic        dec_vld, dec_store, dec_cmd, prot_on, wr_permit;
  logic        o_vld, o_store, o_cmd, o_prot, o_permit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit run_mon = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  wp_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .page_commit(page_commit), .dec_vld(dec_vld), .dec_store(dec_store), .dec_cmd(dec_cmd),
    .prot_on(prot_on), .wr_permit(wr_permit)
  );

  wp_seq #(.PROT_AT_RESET(1'b0)) uut_open (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .page_commit(page_commit), .dec_vld(o_vld), .dec_store(o_store), .dec_cmd(o_cmd),
    .prot_on(o_prot), .wr_permit(o_permit)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: one strobe, expected {store, cmd, prot, permit} pushed
  task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic cm,
                    input logic es, input logic ec, input logic ep, input logic epm,
                    input string tag);
    @(negedge clk);
    wr_strobe = 1'b1; wr_addr = a; wr_data = d; page_commit = cm;
    exp_q.push_back({es, ec, ep, epm});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_strobe = 1'b0; page_commit = 1'b0;
    end
  endtask

  task automatic commit();
    @(negedge clk);
    wr_strobe = 1'b0; page_commit = 1'b1;
    @(negedge clk);
    page_commit = 1'b0;
    chk({3'b0, wr_permit}, 4'b0000, "R5 commit closes window");
  endtask

  // monitor: pops one expected item per verdict
  always @(negedge clk) begin
    if (run_mon && dec_vld) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected verdict actual=1 expected=0");
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({dec_store, dec_cmd, prot_on, wr_permit}, e, t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({dec_vld, dec_store, prot_on, wr_permit}, 4'b0010, "R1 reset state prot");
    chk({o_vld, o_store, o_prot, o_permit}, 4'b0000, "R1 reset state open");
    run_mon = 1'b1;

    // R2 plain write while locked; open instance stores it (R7)
    wr(15'h0100, 8'h3C, 0, 0, 0, 1, 0, "R2 locked write dropped");
    idle(1);
    chk({o_vld, o_store, o_cmd, o_prot}, 4'b1100, "R7 open-reset instance stores");

    // R3 unlock key
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R3 key step 1");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 1, 0, "R3 key step 2");
    wr(15'h5555, 8'hA0, 0, 0, 1, 1, 1, "R3 key step 3 opens window");
    // R4 window stores everything
    wr(15'h0040, 8'h11, 0, 1, 0, 1, 1, "R4 window write stored");
    wr(15'h5555, 8'hAA, 0, 1, 0, 1, 1, "R4 key-valued byte stored in window");
    commit();
    wr(15'h0040, 8'h22, 0, 0, 0, 1, 0, "R5 write after commit dropped");

    // R5 unlock coincident with commit
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R5 key step 1");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 1, 0, "R5 key step 2");
    wr(15'h5555, 8'hA0, 1, 0, 1, 1, 1, "R5 set wins over commit");
    commit();

    // R10 near-miss addresses
    wr(15'h1555, 8'hAA, 0, 0, 0, 1, 0, "R10 bit14 differs");
    wr(15'h5554, 8'hAA, 0, 0, 0, 1, 0, "R10 bit0 differs");
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R10 real step 1");
    wr(15'h2AAB, 8'h55, 0, 0, 0, 1, 0, "R10 second address off by one");

    // R9 break and restart
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R9 step 1");
    wr(15'h0200, 8'h77, 0, 0, 0, 1, 0, "R9 breaking write dropped");
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R9 step 1 again");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 1, 0, "R9 step 2");
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R9 break by first step restarts");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 1, 0, "R9 step 2 after restart");
    wr(15'h5555, 8'hA0, 0, 0, 1, 1, 1, "R9 restarted key opens window");
    commit();

    // R6 disable key with a quiet pause (R11)
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R6 disable 1");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 1, 0, "R6 disable 2");
    wr(15'h5555, 8'h80, 0, 0, 1, 1, 0, "R6 disable 3");
    @(negedge clk);
    wr_strobe = 1'b0; wr_addr = 15'h2AAA; wr_data = 8'h55;
    @(negedge clk);
    wr_addr = 15'h5555; wr_data = 8'h20;
    chk({3'b0, dec_vld}, 4'b0000, "R11 no verdict without strobe");
    @(negedge clk);
    chk({3'b0, dec_vld}, 4'b0000, "R11 still no verdict");
    wr(15'h5555, 8'hAA, 0, 0, 1, 1, 0, "R6 disable 4 after pause");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 1, 0, "R6 disable 5");
    wr(15'h5555, 8'h20, 0, 0, 1, 0, 0, "R6 disable 6 unprotects");

    // R7 unprotected plain write
    wr(15'h0300, 8'h99, 0, 1, 0, 0, 0, "R7 unprotected write stored");
    wr(15'h7FFF, 8'h00, 0, 1, 0, 0, 0, "R7 unprotected write stored 2");

    // R8 unlock key re-protects
    wr(15'h5555, 8'hAA, 0, 0, 1, 0, 0, "R8 key step 1");
    wr(15'h2AAA, 8'h55, 0, 0, 1, 0, 0, "R8 key step 2");
    wr(15'h5555, 8'hA0, 0, 0, 1, 1, 1, "R8 protection re-armed");
    wr(15'h0301, 8'h5A, 0, 1, 0, 1, 1, "R8 window write stored");
    commit();
    wr(15'h0302, 8'h5B, 0, 0, 0, 1, 0, "R8 locked again");
    idle(3);

    chk({3'b0, exp_q.size() == 0}, 4'b0001, "R11 all verdicts seen");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule